// File: doc/BRIEF.md
# Oscillation Stabilization Wait Controller

This block measures the settling interval a clock and reset controller must wait out before it resumes normal operation. Something starts a wait: a stop-mode exit request, a PLL control error strobe, or the release of any reset. When a wait starts, a timebase counter is cleared and counts up. The wait ends once the counter has covered the length picked by a 2-bit select code. The block then lowers its wait-active flag and raises a one-cycle ready pulse.

The select code is written through a small write port. Only the external-pin initialization reset clears it, to the shortest setting. The internal initialization reset and the operation reset leave it alone. The code is copied into the timer when a wait starts, so a later write only affects later waits. A new wait source that arrives during a wait restarts the count from zero.

The control path has three named states. HOLD is entered asynchronously while any reset is high. WAIT is the counting state. RUN is normal operation. The transitions are:
- HOLD→WAIT (reset released)
- WAIT→WAIT (restart on a new source)
- WAIT→RUN (count complete; emits ready)
- RUN→WAIT (new source)
- any→HOLD (reset)

Top module: `osc_wait_ctrl`

## Requirements
- R1: The select code on `cfg_sel` is stored when `cfg_we` is high at a clock edge. Code 0 means no wait, 1 a PLL lock wait of TC_PLL cycles, 2 a medium oscillator wait of TC_MID cycles, and 3 a long oscillator wait of TC_LONG cycles.
- R2: For codes 1 to 3, `wait_active` is high for exactly the code's TC cycles, counted from the edge that samples the wait source, and is low afterwards.
- R3: `ready` is high for exactly one cycle: the first cycle after `wait_active` falls. It is never high while `wait_active` is high.
- R4: An internal initialization reset or an operation reset leaves the stored select code unchanged.
- R5: The external-pin initialization reset forces the stored select code to 0.
- R6: A high level of `pll_err` or of `stop_exit` at a clock edge starts a wait, and both act identically.
- R7: With code 0, `wait_active` is high for one cycle, `ready` follows in the next cycle, and the counter does not advance.
- R8: A wait source during an active wait restarts the count from zero, so the wait ends TC cycles after the last source.
- R9: The select code is captured when a wait starts. A write during a wait changes only the next wait.
- R10: While any reset input is high, `wait_active` is high and `ready` is low. After release, a wait of the retained code's length runs from the first clock edge.
- R11: A wait source at the same edge where a wait would complete restarts the wait and suppresses that `ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_init | input | 1 | Power-on / external-pin initialization reset, active high, asynchronous |
| int_init | input | 1 | Internal initialization reset, active high, asynchronous |
| op_rst | input | 1 | Operation reset, active high, asynchronous |
| stop_exit | input | 1 | Stop-mode exit request, starts a wait |
| pll_err | input | 1 | PLL control error strobe, starts a wait |
| cfg_we | input | 1 | Write enable for the select code |
| cfg_sel | input | 2 | Select code to be written |
| wait_active | output | 1 | High while the controller is waiting or held in reset |
| ready | output | 1 | One-cycle pulse when a wait completes |

## Verification
Two functions can fall on the same edge: completion of a wait, and the arrival of a new wait source. The bench provokes this by raising `pll_err` exactly at the edge where a 5-cycle wait would finish. It then judges that `ready` stays low and that a full fresh wait follows. A second overlap pairs a select write with an active wait. The shorter original length must hold, and the newly written length must show up only on the following wait.

// File: rtl/osc_wait_pkg.sv
`timescale 1ns/1ps
package osc_wait_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } ow_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PLL  = 2'd1,
        SEL_MID  = 2'd2,
        SEL_LONG = 2'd3
    } ow_sel_e;
endpackage

// File: rtl/osc_wait_sel_reg.sv
`timescale 1ns/1ps
module osc_wait_sel_reg
    import osc_wait_pkg::*;
(
    input  logic       clk,
    input  logic       ext_init,
    input  logic       we,
    input  logic [1:0] wdata,
    output ow_sel_e    sel_q
);
    // Only the pin-driven initialization clears the setting.
    always_ff @(posedge clk or posedge ext_init) begin
        if (ext_init) begin
            sel_q <= SEL_NONE;
        end else if (we) begin
            sel_q <= ow_sel_e'(wdata);
        end
    end

    assert_sel_keep_R4: assert property (@(posedge clk) disable iff (ext_init)
        !we |=> $stable(sel_q));
endmodule

// File: rtl/osc_wait_timer.sv
`timescale 1ns/1ps
module osc_wait_timer
    import osc_wait_pkg::*;
#(
    parameter int TC_PLL  = 1024,
    parameter int TC_MID  = 16384,
    parameter int TC_LONG = 131072
) (
    input  logic    clk,
    input  logic    arst,
    input  logic    start,
    input  logic    en,
    input  ow_sel_e sel_in,
    output logic    done
);
    localparam int CW = $clog2(TC_LONG + 1);
    localparam logic [CW-1:0] LIM_PLL  = CW'(TC_PLL - 1);
    localparam logic [CW-1:0] LIM_MID  = CW'(TC_MID - 1);
    localparam logic [CW-1:0] LIM_LONG = CW'(TC_LONG - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    ow_sel_e       lat_q;

    always_comb begin
        unique case (lat_q)
            SEL_PLL:  lim = LIM_PLL;
            SEL_MID:  lim = LIM_MID;
            SEL_LONG: lim = LIM_LONG;
            default:  lim = '0;
        endcase
    end

    assign done = (lat_q == SEL_NONE) || (cnt_q == lim);

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt_q <= '0;
            lat_q <= SEL_NONE;
        end else if (start) begin
            cnt_q <= '0;
            lat_q <= sel_in;
        end else if (en && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_limit_R2: assert property (@(posedge clk) disable iff (arst)
        en |-> (cnt_q <= lim));
    assert_none_still_R7: assert property (@(posedge clk) disable iff (arst)
        (lat_q == SEL_NONE) |-> (cnt_q == '0));
endmodule

// File: rtl/osc_wait_fsm.sv
`timescale 1ns/1ps
module osc_wait_fsm
    import osc_wait_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic src,
    input  logic done,
    output logic start,
    output logic cnt_en,
    output logic wait_active,
    output logic ready
);
    ow_state_e state_q, state_d;
    logic      finish;

    // Next-state logic: a source always wins over completion.
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                state_d = ST_WAIT;
                start   = 1'b1;
            end
            ST_WAIT: begin
                if (src) begin
                    start = 1'b1;
                end else if (done) begin
                    state_d = ST_RUN;
                    finish  = 1'b1;
                end
            end
            ST_RUN: begin
                if (src) begin
                    state_d = ST_WAIT;
                    start   = 1'b1;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            ready <= 1'b0;
        end else begin
            ready <= finish;
        end
    end

    assign cnt_en      = (state_q == ST_WAIT);
    assign wait_active = (state_q != ST_RUN);

    assert_src_starts_R6: assert property (@(posedge clk) disable iff (arst)
        src |=> (wait_active && !ready));
    assert_ready_single_R3: assert property (@(posedge clk) disable iff (arst)
        ready |=> !ready);
    assert_ready_idle_R3: assert property (@(posedge clk) disable iff (arst)
        ready |-> !wait_active);
endmodule

// File: rtl/osc_wait_ctrl.sv
`timescale 1ns/1ps
module osc_wait_ctrl
    import osc_wait_pkg::*;
#(
    parameter int TC_PLL  = 1024,
    parameter int TC_MID  = 16384,
    parameter int TC_LONG = 131072
) (
    input  logic       clk,
    input  logic       ext_init,
    input  logic       int_init,
    input  logic       op_rst,
    input  logic       stop_exit,
    input  logic       pll_err,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    output logic       wait_active,
    output logic       ready
);
    logic    rst_any;
    logic    src;
    logic    start;
    logic    cnt_en;
    logic    done;
    ow_sel_e sel_q;

    assign rst_any = ext_init | int_init | op_rst;
    assign src     = stop_exit | pll_err;

    osc_wait_sel_reg u_sel (
        .clk      (clk),
        .ext_init (ext_init),
        .we       (cfg_we),
        .wdata    (cfg_sel),
        .sel_q    (sel_q)
    );

    osc_wait_timer #(
        .TC_PLL  (TC_PLL),
        .TC_MID  (TC_MID),
        .TC_LONG (TC_LONG)
    ) u_tmr (
        .clk    (clk),
        .arst   (rst_any),
        .start  (start),
        .en     (cnt_en),
        .sel_in (sel_q),
        .done   (done)
    );

    osc_wait_fsm u_fsm (
        .clk         (clk),
        .arst        (rst_any),
        .src         (src),
        .done        (done),
        .start       (start),
        .cnt_en      (cnt_en),
        .wait_active (wait_active),
        .ready       (ready)
    );

    assert_ext_clears_R5: assert property (@(posedge clk)
        ext_init |-> (sel_q == SEL_NONE));
endmodule

// File: tb/osc_wait_ctrl_test.sv
`timescale 1ns/1ps
module osc_wait_ctrl_test;
    localparam int T1 = 5;
    localparam int T2 = 9;
    localparam int T3 = 14;

    logic       clk = 1'b0;
    logic       ext_init = 1'b1;
    logic       int_init = 1'b0;
    logic       op_rst = 1'b0;
    logic       stop_exit = 1'b0;
    logic       pll_err = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic       wait_active;
    logic       ready;

    int checks = 0;
    int errs = 0;

    always #2 clk = ~clk;

    osc_wait_ctrl #(.TC_PLL(T1), .TC_MID(T2), .TC_LONG(T3)) uut (
        .clk(clk), .ext_init(ext_init), .int_init(int_init), .op_rst(op_rst),
        .stop_exit(stop_exit), .pll_err(pll_err), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .wait_active(wait_active), .ready(ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count cycles of wait_active starting at the current negedge, then
    // check the ready pulse and its single-cycle width.
    task automatic measure(input string req, input int exp_len, input int offset);
        int  n = 0;
        bit  early = 0;
        while (wait_active && n < 100) begin
            if (ready) early = 1;
            n++;
            @(negedge clk);
        end
        check({req, " length"}, n + offset, exp_len);
        check({"R3 no ready while active (", req, ")"}, int'(early), 0);
        check({"R3 ready after wait (", req, ")"}, int'(ready), 1);
        @(negedge clk);
        check({"R3 ready one cycle (", req, ")"}, int'(ready), 0);
    endtask

    task automatic write_sel(input logic [1:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_src(input bit use_stop);
        @(negedge clk);
        if (use_stop) stop_exit = 1'b1; else pll_err = 1'b1;
        @(negedge clk);
        stop_exit = 1'b0;
        pll_err = 1'b0;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R10 active in ext reset", int'(wait_active), 1);
        check("R10 ready low in reset", int'(ready), 0);
        ext_init = 1'b0;
        @(negedge clk);
        measure("R5 R7 code0 after ext_init", 1, 0);
    endtask

    task automatic t_codes;
        write_sel(2'd1);
        pulse_src(0);
        measure("R1 R2 R6 pll_err code1", T1, 0);
        write_sel(2'd2);
        pulse_src(1);
        measure("R1 R2 R6 stop_exit code2", T2, 0);
        write_sel(2'd3);
        pulse_src(1);
        measure("R1 R2 code3", T3, 0);
        write_sel(2'd0);
        pulse_src(0);
        measure("R7 code0 written", 1, 0);
    endtask

    task automatic t_retain;
        write_sel(2'd2);
        @(negedge clk);
        int_init = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 active in int_init", int'(wait_active), 1);
        int_init = 1'b0;
        @(negedge clk);
        measure("R4 R10 int_init keeps code2", T2, 0);
        write_sel(2'd3);
        op_rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 ready low in op_rst", int'(ready), 0);
        op_rst = 1'b0;
        @(negedge clk);
        measure("R4 R10 op_rst keeps code3", T3, 0);
        ext_init = 1'b1;
        @(negedge clk);
        ext_init = 1'b0;
        @(negedge clk);
        measure("R5 ext_init clears code3", 1, 0);
    endtask

    task automatic t_restart;
        write_sel(2'd1);
        pulse_src(0);
        repeat (2) @(negedge clk);
        pulse_src(1);
        measure("R8 restart from zero", T1, 0);
    endtask

    task automatic t_sample_at_start;
        write_sel(2'd1);
        @(negedge clk);
        pll_err = 1'b1;
        @(negedge clk);
        pll_err = 1'b0;
        cfg_we = 1'b1;
        cfg_sel = 2'd3;
        @(negedge clk);
        cfg_we = 1'b0;
        measure("R9 write during wait ignored", T1, 1);
        pulse_src(0);
        measure("R9 write used by next wait", T3, 0);
    endtask

    task automatic t_coincide;
        write_sel(2'd1);
        pulse_src(0);
        repeat (T1 - 1) @(negedge clk);
        pll_err = 1'b1;
        @(negedge clk);
        pll_err = 1'b0;
        check("R11 no ready on coincident source", int'(ready), 0);
        measure("R11 fresh wait after coincidence", T1, 0);
    endtask

    initial begin
        #(200000 * 4);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_codes();
        t_retain();
        t_restart();
        t_sample_at_start();
        t_coincide();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule